// File: doc/BRIEF.md
# DVI Raster Frame Timing Sequencer

This block sequences a progressive 640x480 raster for a DVI transmitter, one step per pixel clock. The pixel clock runs at one tenth of the serial bit rate, so 25 MHz for this mode. For every pixel it reports four things: whether the pixel lies in the visible area, the visible column and row, and a 2-bit control code for each of the three colour lanes. The encoder behind it sends those control codes while video is blanked. Nothing here fetches pixels, encodes TMDS symbols or serialises them.

Each line begins with its front porch. The horizontal sync pulse follows, then the back porch, then the visible pixels. Each frame begins with the upper blanking lines. The visible lines follow, then the lower blanking lines. The vertical sync lines come last, and then the frame repeats.

Sync is not sent on separate wires. It travels in the blue lane control code. The red and green lane codes stay at zero for plain DVI. An optional request input switches red and green to the data-island preamble code while video is blanked. A one-clock start-of-frame strobe marks the first visible pixel.

Top module: `dvi_frame_seq`

## Requirements
- R1: A line lasts H_FP+H_SYNC+H_BP+H_ACT clocks (default 16+96+48+640 = 800). It is made of a front porch, then the sync region, then the back porch, then the visible region, in that order.
- R2: A frame lasts V_TOP+V_ACT+V_BOT+V_SYNC lines (default 25+480+18+2 = 525). It is made of the upper blanking lines, then the visible lines, then the lower blanking lines, then the vertical sync lines, in that order. After that the next frame begins.
- R3: `de` is 1 only during the visible clocks of visible lines. While `de` is 1, `col` counts from 0 to H_ACT-1 along the line and `row` counts from 0 to V_ACT-1 down the frame. While `de` is 0, both read 0.
- R4: Bit 0 of `ctl_blue` is the horizontal sync. It is 1 exactly during the sync region of every line, in every part of the frame.
- R5: Bit 1 of `ctl_blue` is the vertical sync. It is 1 on every clock of the vertical sync lines, porches included, and 0 on every other line. The blue code therefore reads 0 for no sync, 1 for horizontal only, 2 for vertical only and 3 for both.
- R6: `ctl_red` and `ctl_green` are both 2'b00 whenever `island_req` is 0. They are also 2'b00 whenever `de` is 1, so `island_req` has no effect during visible pixels.
- R7: While `de` is 0 and `island_req` is 1, `ctl_red` and `ctl_green` are both 2'b01. `ctl_blue` keeps showing the current sync state.
- R8: `sof` is 1 for exactly one clock per frame. That clock is the first visible pixel of the first visible line (`de`=1, `col`=0, `row`=0).
- R9: `rst_n` low clears the sequencer asynchronously. The first clock after release is front-porch clock 0 of upper blanking line 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| island_req | input | 1 | Request for the data-island preamble code on red and green |
| de | output | 1 | Visible-pixel flag |
| col | output | $clog2(H_ACT) | Visible column, 0 when not visible |
| row | output | $clog2(V_ACT) | Visible row, 0 when not visible |
| ctl_blue | output | 2 | Blue lane control code: bit 1 vsync, bit 0 hsync |
| ctl_green | output | 2 | Green lane control code |
| ctl_red | output | 2 | Red lane control code |
| sof | output | 1 | One-clock start-of-frame strobe |

## Verification
The bench shrinks the raster to 3+4+2+8 clocks per line and 2+4+3+2 lines per frame. With those values a full frame lasts 187 clocks, so several whole frames fit in a short run. That brings every line wrap, every frame wrap, both vertical sync lines and the start-of-frame strobe within reach many times over. The island request is driven as a constant 0, as a constant 1 and at random. One reset is applied in the middle of a frame, between clock edges, to show that the restart point does not depend on the clock.

// File: rtl/dvi_seq_pkg.sv
`timescale 1ns/1ps
package dvi_seq_pkg;

  // Horizontal region of the current clock
  typedef enum logic [1:0] {
    HZ_FRONT  = 2'd0,
    HZ_SYNC   = 2'd1,
    HZ_BACK   = 2'd2,
    HZ_ACTIVE = 2'd3
  } hzone_t;

  // Vertical region of the current line
  typedef enum logic [1:0] {
    VZ_TOP    = 2'd0,
    VZ_ACTIVE = 2'd1,
    VZ_BOTTOM = 2'd2,
    VZ_SYNC   = 2'd3
  } vzone_t;

  // Lane control code values
  localparam logic [1:0] CTL_IDLE     = 2'b00;
  localparam logic [1:0] CTL_PREAMBLE = 2'b01;

endpackage

// File: rtl/dvi_hcount.sv
`timescale 1ns/1ps
module dvi_hcount
  import dvi_seq_pkg::*;
#(
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int H_ACT  = 640,
  localparam int H_TOTAL = H_FP + H_SYNC + H_BP + H_ACT,
  localparam int HW      = $clog2(H_TOTAL),
  localparam int CW      = (H_ACT > 1) ? $clog2(H_ACT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  output hzone_t        zone,
  output logic          line_end,
  output logic [CW-1:0] hcol
);

  localparam logic [HW-1:0] SYNC_BEG = HW'(H_FP);
  localparam logic [HW-1:0] BACK_BEG = HW'(H_FP + H_SYNC);
  localparam logic [HW-1:0] ACT_BEG  = HW'(H_FP + H_SYNC + H_BP);
  localparam logic [HW-1:0] LAST     = HW'(H_TOTAL - 1);

  logic [HW-1:0] h_cnt;
  logic [HW-1:0] h_nxt;
  logic [HW-1:0] h_off;

  // next-state
  always_comb begin
    h_nxt = h_cnt;
    if (en) begin
      if (h_cnt == LAST) h_nxt = '0;
      else               h_nxt = h_cnt + 1'b1;
    end
  end

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) h_cnt <= '0;
    else        h_cnt <= h_nxt;
  end

  // region decode
  always_comb begin
    if (h_cnt >= ACT_BEG)       zone = HZ_ACTIVE;
    else if (h_cnt >= BACK_BEG) zone = HZ_BACK;
    else if (h_cnt >= SYNC_BEG) zone = HZ_SYNC;
    else                        zone = HZ_FRONT;
  end

  assign line_end = en && (h_cnt == LAST);
  assign h_off    = h_cnt - ACT_BEG;
  assign hcol     = (zone == HZ_ACTIVE) ? h_off[CW-1:0] : '0;

  // R1: line wraps back to its first front-porch clock
  a_r1_line_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (en && h_cnt == LAST) |=> (h_cnt == '0));

  // R1: region order, sync follows front porch directly
  a_r1_sync_after_front: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && zone == HZ_SYNC && $past(zone) != HZ_SYNC) |-> ($past(zone) == HZ_FRONT));

endmodule

// File: rtl/dvi_vcount.sv
`timescale 1ns/1ps
module dvi_vcount
  import dvi_seq_pkg::*;
#(
  parameter int V_TOP  = 25,
  parameter int V_ACT  = 480,
  parameter int V_BOT  = 18,
  parameter int V_SYNC = 2,
  localparam int V_TOTAL = V_TOP + V_ACT + V_BOT + V_SYNC,
  localparam int VW      = $clog2(V_TOTAL),
  localparam int RW      = (V_ACT > 1) ? $clog2(V_ACT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output vzone_t        zone,
  output logic [RW-1:0] vrow
);

  localparam logic [VW-1:0] ACT_BEG  = VW'(V_TOP);
  localparam logic [VW-1:0] BOT_BEG  = VW'(V_TOP + V_ACT);
  localparam logic [VW-1:0] SYNC_BEG = VW'(V_TOP + V_ACT + V_BOT);
  localparam logic [VW-1:0] LAST     = VW'(V_TOTAL - 1);

  logic [VW-1:0] v_cnt;
  logic [VW-1:0] v_nxt;
  logic [VW-1:0] v_off;

  // next-state: advances only on the last clock of a line
  always_comb begin
    v_nxt = v_cnt;
    if (adv) begin
      if (v_cnt == LAST) v_nxt = '0;
      else               v_nxt = v_cnt + 1'b1;
    end
  end

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_cnt <= '0;
    else        v_cnt <= v_nxt;
  end

  // region decode
  always_comb begin
    if (v_cnt >= SYNC_BEG)     zone = VZ_SYNC;
    else if (v_cnt >= BOT_BEG) zone = VZ_BOTTOM;
    else if (v_cnt >= ACT_BEG) zone = VZ_ACTIVE;
    else                       zone = VZ_TOP;
  end

  assign v_off = v_cnt - ACT_BEG;
  assign vrow  = (zone == VZ_ACTIVE) ? v_off[RW-1:0] : '0;

  // R2: line index stays put within a line
  a_r2_hold_midline: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(v_cnt));

  // R2: frame restarts at the first upper blanking line
  a_r2_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && v_cnt == LAST) |=> (zone == VZ_TOP && v_cnt == '0));

endmodule

// File: rtl/dvi_ctl_enc.sv
`timescale 1ns/1ps
module dvi_ctl_enc
  import dvi_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  hzone_t     hz,
  input  vzone_t     vz,
  input  logic       island_req,
  output logic       de,
  output logic [1:0] ctl_blue,
  output logic [1:0] ctl_green,
  output logic [1:0] ctl_red
);

  logic hs;
  logic vs;
  logic pre;

  always_comb begin
    de  = (hz == HZ_ACTIVE) && (vz == VZ_ACTIVE);
    hs  = (hz == HZ_SYNC);
    vs  = (vz == VZ_SYNC);
    pre = island_req && !de;
    ctl_blue  = {vs, hs};
    ctl_green = pre ? CTL_PREAMBLE : CTL_IDLE;
    ctl_red   = pre ? CTL_PREAMBLE : CTL_IDLE;
  end

  // R6: request has no effect on visible pixels
  a_r6_rg_idle_in_active: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (ctl_red == CTL_IDLE && ctl_green == CTL_IDLE));

  // R4: no sync code while pixels are visible
  a_r4_blue_quiet_in_active: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (ctl_blue == 2'b00));

endmodule

// File: rtl/dvi_frame_seq.sv
`timescale 1ns/1ps
module dvi_frame_seq
  import dvi_seq_pkg::*;
#(
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int H_ACT  = 640,
  parameter int V_TOP  = 25,
  parameter int V_ACT  = 480,
  parameter int V_BOT  = 18,
  parameter int V_SYNC = 2,
  localparam int CW = (H_ACT > 1) ? $clog2(H_ACT) : 1,
  localparam int RW = (V_ACT > 1) ? $clog2(V_ACT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          island_req,
  output logic          de,
  output logic [CW-1:0] col,
  output logic [RW-1:0] row,
  output logic [1:0]    ctl_blue,
  output logic [1:0]    ctl_green,
  output logic [1:0]    ctl_red,
  output logic          sof
);

  hzone_t        hz;
  vzone_t        vz;
  logic          line_end;
  logic [CW-1:0] hcol;
  logic [RW-1:0] vrow;
  logic          pix_en;

  // pixel clock enable, written out: the raster advances every clock
  assign pix_en = 1'b1;

  dvi_hcount #(
    .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP), .H_ACT(H_ACT)
  ) u_hcount (
    .clk(clk), .rst_n(rst_n), .en(pix_en),
    .zone(hz), .line_end(line_end), .hcol(hcol)
  );

  dvi_vcount #(
    .V_TOP(V_TOP), .V_ACT(V_ACT), .V_BOT(V_BOT), .V_SYNC(V_SYNC)
  ) u_vcount (
    .clk(clk), .rst_n(rst_n), .adv(line_end),
    .zone(vz), .vrow(vrow)
  );

  dvi_ctl_enc u_ctl (
    .clk(clk), .rst_n(rst_n), .hz(hz), .vz(vz), .island_req(island_req),
    .de(de), .ctl_blue(ctl_blue), .ctl_green(ctl_green), .ctl_red(ctl_red)
  );

  assign col = de ? hcol : '0;
  assign row = de ? vrow : '0;
  assign sof = de && (hcol == '0) && (vrow == '0);

  // R8: strobe lasts one clock
  a_r8_sof_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> !sof);

  // R3: column steps by one along a visible run
  a_r3_col_step: assert property (@(posedge clk) disable iff (!rst_n)
    (de && $past(de)) |-> (col == $past(col) + 1'b1));

  // R3: position reads zero outside the visible area
  a_r3_pos_zero_blank: assert property (@(posedge clk) disable iff (!rst_n)
    !de |-> (col == '0 && row == '0));

  // R8: strobe only with the visible flag
  a_r8_sof_with_de: assert property (@(posedge clk) disable iff (!rst_n)
    sof |-> de);

endmodule

// File: tb/dvi_frame_seq_tb.sv
`timescale 1ns/1ps
module dvi_frame_seq_tb;

  localparam int FP = 3, SY = 4, BP = 2, HA = 8;
  localparam int VT_TOP = 2, VA = 4, VB = 3, VS = 2;
  localparam int HT = FP + SY + BP + HA;
  localparam int VT = VT_TOP + VA + VB + VS;
  localparam int FR = HT * VT;
  localparam int CW = $clog2(HA);
  localparam int RW = $clog2(VA);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          island_req;
  logic          de;
  logic [CW-1:0] col;
  logic [RW-1:0] row;
  logic [1:0]    ctl_blue, ctl_green, ctl_red;
  logic          sof;

  int vectors = 0;
  int errors  = 0;
  int k       = 0;
  int sof_seen = 0;

  always #2 clk = ~clk;

  dvi_frame_seq #(
    .H_FP(FP), .H_SYNC(SY), .H_BP(BP), .H_ACT(HA),
    .V_TOP(VT_TOP), .V_ACT(VA), .V_BOT(VB), .V_SYNC(VS)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .island_req(island_req),
    .de(de), .col(col), .row(row),
    .ctl_blue(ctl_blue), .ctl_green(ctl_green), .ctl_red(ctl_red), .sof(sof)
  );

  function automatic int exp_hs(int t);
    int h = t % HT;
    return (h >= FP && h < FP + SY) ? 1 : 0;
  endfunction

  function automatic int exp_vs(int t);
    int v = (t / HT) % VT;
    return (v >= VT_TOP + VA + VB) ? 1 : 0;
  endfunction

  function automatic int exp_de(int t);
    int h = t % HT;
    int v = (t / HT) % VT;
    return (h >= FP + SY + BP && v >= VT_TOP && v < VT_TOP + VA) ? 1 : 0;
  endfunction

  function automatic int exp_col(int t);
    return exp_de(t) ? (t % HT) - (FP + SY + BP) : 0;
  endfunction

  function automatic int exp_row(int t);
    return exp_de(t) ? ((t / HT) % VT) - VT_TOP : 0;
  endfunction

  function automatic int exp_rg(int t, logic req);
    return (req && !exp_de(t)) ? 1 : 0;
  endfunction

  function automatic int exp_sof(int t);
    return (exp_de(t) && exp_col(t) == 0 && exp_row(t) == 0) ? 1 : 0;
  endfunction

  task automatic chk(string tag, int act, int expv);
    vectors++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s at step %0d: actual %0d expected %0d", tag, k, act, expv);
    end
  endtask

  task automatic check_all();
    chk("R3 de",               int'(de),           exp_de(k));
    chk("R1 R3 col",           int'(col),          exp_col(k));
    chk("R2 R3 row",           int'(row),          exp_row(k));
    chk("R1 R4 hsync",         int'(ctl_blue[0]),  exp_hs(k));
    chk("R2 R5 vsync",         int'(ctl_blue[1]),  exp_vs(k));
    chk(island_req ? "R7 red" : "R6 red",     int'(ctl_red),   exp_rg(k, island_req));
    chk(island_req ? "R7 green" : "R6 green", int'(ctl_green), exp_rg(k, island_req));
    chk("R8 sof",              int'(sof),          exp_sof(k));
    if (sof) sof_seen++;
  endtask

  // mode 0: request low, 1: request high, 2: random
  task automatic run(int n, int mode);
    for (int i = 0; i < n; i++) begin
      case (mode)
        0:       island_req = 1'b0;
        1:       island_req = 1'b1;
        default: island_req = 1'($urandom % 2);
      endcase
      #1;
      check_all();
      k++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0D71));
    rst_n = 1'b0;
    island_req = 1'b0;
    repeat (3) @(negedge clk);
    // R9: state held at the first front-porch clock while in reset
    k = 0;
    #1;
    check_all();
    chk("R9 reset blue", int'(ctl_blue), 0);
    @(negedge clk);
    rst_n = 1'b1;
    k = 0;
    run(FR + 5, 0);
    run(2 * FR, 2);
    // R9: asynchronous reset in the middle of a frame
    run(FR / 2 + 3, 2);
    #1;
    rst_n = 1'b0;
    #0.5;
    k = 0;
    island_req = 1'b0;
    #0.1;
    check_all();
    chk("R9 async de", int'(de), 0);
    @(negedge clk);
    rst_n = 1'b1;
    k = 0;
    run(FR + 2, 1);
    run(FR, 2);
    // R8: exactly one strobe per completed frame
    chk("R8 sof count", sof_seen, 1 + 2 + 1 + 1 + 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule